// File: doc/BRIEF.md
# Stop Mode Power Controller

This block sequences a small controller-style system into and out of its lowest-power halt state. Software asks for the halt by writing a one to a stop control bit. From the next cycle the core clock enable drops. The oscillator, PLL and real-time-clock enables stay active only where their own conditions allow. The port pins are either released to high impedance or frozen at their last value. The pin choice is sampled once, when the halt begins. External-interrupt inputs need no clock, so they stay usable in either pin choice.

Leaving the halt always passes through a counted wait, so the oscillator can settle before the core clock returns. The length of this wait comes from a programmable down-counter. A clockless external interrupt, or a real-time-clock interrupt while that clock is running, starts the wake-up wait. An initialization request from a pin or a watchdog forces an initialization reset. When the request is released and the same settling wait has run out, the block issues a one-cycle operation reset. The block itself runs on a free-running oscillator clock and is not gated.

Top module: `stop_pwr_ctl`

## Requirements
- R1: After `rst_n` is released, `pwr_state` is 0 (run), `core_clk_en` is 1, and `stop_bit`, `pin_hiz`, `pin_hold`, `init_rst` and `op_rst` are all 0.
- R2: In run state, a cycle with `stop_wr`=1 and `stop_wdata`=1 and no wake or init request gives `pwr_state`=1 (stop) on the next cycle. It also gives `core_clk_en`=0 and `stop_bit`=1. The block stays in stop for as long as no wake or init request arrives. A write of 0 has no effect.
- R3: While `pwr_state` is 1 or 2, `pin_hiz` equals the value `hiz_sel` had in the accepted stop write, and `pin_hold` is its inverse. Changes to `hiz_sel` during that time are ignored. In states 0 and 3, both pin outputs are 0.
- R4: `main_osc_run` follows `main_osc_en` and `sub_osc_run` follows `sub_osc_en` in every state.
- R5: `pll_run` needs `pll_en` and `main_osc_en`. In any state other than run, it also needs `main_reg_on`.
- R6: `rtc_clk_en` is `rtc_en` ANDed with the enable of the selected oscillator: sub when `rtc_src_sub`=1, main otherwise. When `rtc_clk_en` is 0, `rtc_irq` wakes nothing.
- R7: In stop, `ext_wake`, or `rtc_irq` with `rtc_clk_en`, gives `pwr_state`=2 (settle wait) on the next cycle. The counter loads `stab_cycles` at that point. The wait lasts `stab_cycles`+1 cycles, and then the block returns to run with `stop_bit` reading 0. Changes to `stab_cycles` during the wait are ignored.
- R8: A wake event in the same cycle as an accepted stop write goes straight to `pwr_state`=2.
- R9: `init_req` in any state gives `pwr_state`=3 on the next cycle, with `init_rst`=1 and `core_clk_en`=0. The block stays in state 3 while the request is held. After release, it spends `stab_cycles`+1 cycles counting, then returns to run with `op_rst`=1 for exactly one cycle.
- R10: When `init_req` and a wake event arrive in the same cycle, the init request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| stop_wr | input | 1 | Write strobe for the stop control bit |
| stop_wdata | input | 1 | Value written to the stop control bit |
| hiz_sel | input | 1 | Pin choice for stop: 1 high impedance, 0 hold |
| stab_cycles | input | CNT_W | Settling wait length minus one |
| main_osc_en | input | 1 | Main oscillator enabled |
| sub_osc_en | input | 1 | Sub oscillator enabled |
| pll_en | input | 1 | PLL enabled |
| main_reg_on | input | 1 | Main regulator kept on during stop |
| rtc_en | input | 1 | Real-time clock enabled |
| rtc_src_sub | input | 1 | Real-time clock source: 1 sub, 0 main |
| ext_wake | input | 1 | Clockless external interrupt request |
| rtc_irq | input | 1 | Real-time clock interrupt request |
| init_req | input | 1 | INIT pin or watchdog reset request |
| pwr_state | output | 2 | 0 run, 1 stop, 2 settle wait, 3 init reset |
| stop_bit | output | 1 | Readback of the stop control bit |
| core_clk_en | output | 1 | Internal clock gate enable |
| pin_hiz | output | 1 | Drive port pins to high impedance |
| pin_hold | output | 1 | Hold port pins at their last value |
| main_osc_run | output | 1 | Main oscillator running |
| sub_osc_run | output | 1 | Sub oscillator running |
| pll_run | output | 1 | PLL running |
| rtc_clk_en | output | 1 | Real-time clock receives its clock |
| init_rst | output | 1 | Initialization reset active |
| op_rst | output | 1 | One-cycle operation reset |

## Verification
Directed sequences take the block through every path:
- a plain stop;
- a real-time-clock wake that is blocked and then allowed, which separates a qualified interrupt from a raw one;
- a wake in the same cycle as the stop write, which tells an immediate settle wait from a stuck stop;
- an init request together with a wake, which shows the reset wins.

The wait and reset-release lengths are measured against the loaded value and its plus-one convention. A change of `stab_cycles` in mid-wait shows the count was latched at entry.

A seeded random phase then mixes stop writes, wake pulses, rare init requests and changing oscillator settings. A cycle model built from the requirements separates correct pin choice, PLL gating and state ordering from errors that only appear when events overlap.

// File: rtl/stop_pwr_ctl.sv
`timescale 1ns/1ps
module stop_pwr_ctl #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_wr,
  input  logic             stop_wdata,
  input  logic             hiz_sel,
  input  logic [CNT_W-1:0] stab_cycles,
  input  logic             main_osc_en,
  input  logic             sub_osc_en,
  input  logic             pll_en,
  input  logic             main_reg_on,
  input  logic             rtc_en,
  input  logic             rtc_src_sub,
  input  logic             ext_wake,
  input  logic             rtc_irq,
  input  logic             init_req,
  output logic [1:0]       pwr_state,
  output logic             stop_bit,
  output logic             core_clk_en,
  output logic             pin_hiz,
  output logic             pin_hold,
  output logic             main_osc_run,
  output logic             sub_osc_run,
  output logic             pll_run,
  output logic             rtc_clk_en,
  output logic             init_rst,
  output logic             op_rst
);
  localparam logic [1:0] S_RUN  = 2'd0;
  localparam logic [1:0] S_STOP = 2'd1;
  localparam logic [1:0] S_WAIT = 2'd2;
  localparam logic [1:0] S_RSTW = 2'd3;
  localparam logic [CNT_W-1:0] ONE = 1;

  logic [1:0]       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             mode_q, op_q;
  logic             wake, stop_req, cnt_zero, halted;

  assign rtc_clk_en = rtc_en & (rtc_src_sub ? sub_osc_en : main_osc_en);
  assign wake       = ext_wake | (rtc_irq & rtc_clk_en);
  assign stop_req   = stop_wr & stop_wdata;
  assign cnt_zero   = (cnt_q == '0);
  assign halted     = (st_q == S_STOP) | (st_q == S_WAIT);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (init_req) begin
      st_d  = S_RSTW;
      cnt_d = stab_cycles;
    end else begin
      case (st_q)
        S_RUN: if (stop_req) begin
          st_d  = wake ? S_WAIT : S_STOP;
          cnt_d = stab_cycles;
        end
        S_STOP: if (wake) begin
          st_d  = S_WAIT;
          cnt_d = stab_cycles;
        end
        default: if (cnt_zero) st_d = S_RUN;
                 else          cnt_d = cnt_q - ONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_RUN;
      cnt_q  <= '0;
      mode_q <= 1'b0;
      op_q   <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      op_q  <= (st_q == S_RSTW) & ~init_req & cnt_zero;
      if ((st_q == S_RUN) && stop_req && !init_req) mode_q <= hiz_sel;
    end
  end

  assign pwr_state    = st_q;
  assign stop_bit     = halted;
  assign core_clk_en  = (st_q == S_RUN);
  assign pin_hiz      = halted & mode_q;
  assign pin_hold     = halted & ~mode_q;
  assign main_osc_run = main_osc_en;
  assign sub_osc_run  = sub_osc_en;
  assign pll_run      = pll_en & main_osc_en & (core_clk_en | main_reg_on);
  assign init_rst     = (st_q == S_RSTW);
  assign op_rst       = op_q;

  AST_STOP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == S_RUN && stop_req && !wake && !init_req) |=> (!core_clk_en && stop_bit && pwr_state == S_STOP)); // R2
  AST_PIN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pin_hiz && pin_hold)); // R3
  AST_PIN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_bit && $past(stop_bit)) |-> $stable(pin_hiz)); // R3
  AST_PLL_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    !main_osc_en |-> !pll_run); // R5
  AST_WAKE_TO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == S_STOP && wake && !init_req) |=> (pwr_state == S_WAIT)); // R7
  AST_SAME_CYCLE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == S_RUN && stop_req && wake && !init_req) |=> (pwr_state == S_WAIT)); // R8
  AST_OPRST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    op_rst |=> !op_rst); // R9
  AST_RESET_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    init_req |=> (init_rst && !core_clk_en)); // R10
endmodule

// File: tb/stop_pwr_ctl_test.sv
`timescale 1ns/1ps
module stop_pwr_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic stop_wr = 0, stop_wdata = 0, hiz_sel = 0;
  logic [CW-1:0] stab_cycles = '0;
  logic main_osc_en = 1, sub_osc_en = 1, pll_en = 1, main_reg_on = 1;
  logic rtc_en = 0, rtc_src_sub = 0, ext_wake = 0, rtc_irq = 0, init_req = 0;
  logic [1:0] pwr_state;
  logic stop_bit, core_clk_en, pin_hiz, pin_hold, main_osc_run, sub_osc_run;
  logic pll_run, rtc_clk_en, init_rst, op_rst;

  stop_pwr_ctl #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .stop_wr(stop_wr), .stop_wdata(stop_wdata),
    .hiz_sel(hiz_sel), .stab_cycles(stab_cycles), .main_osc_en(main_osc_en),
    .sub_osc_en(sub_osc_en), .pll_en(pll_en), .main_reg_on(main_reg_on),
    .rtc_en(rtc_en), .rtc_src_sub(rtc_src_sub), .ext_wake(ext_wake),
    .rtc_irq(rtc_irq), .init_req(init_req), .pwr_state(pwr_state),
    .stop_bit(stop_bit), .core_clk_en(core_clk_en), .pin_hiz(pin_hiz),
    .pin_hold(pin_hold), .main_osc_run(main_osc_run), .sub_osc_run(sub_osc_run),
    .pll_run(pll_run), .rtc_clk_en(rtc_clk_en), .init_rst(init_rst), .op_rst(op_rst));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  int m_st = 0, m_cnt = 0;
  bit m_mode = 0, m_op = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_rtc();
    return rtc_en & (rtc_src_sub ? sub_osc_en : main_osc_en);
  endfunction

  function automatic bit exp_pll();
    return pll_en & main_osc_en & ((m_st == 0) | main_reg_on);
  endfunction

  task automatic compare();
    bit halted;
    halted = (m_st == 1) || (m_st == 2);
    chk("R7 pwr_state", pwr_state, m_st);
    chk("R2 core_clk_en", core_clk_en, m_st == 0);
    chk("R2 stop_bit", stop_bit, halted);
    chk("R3 pin_hiz", pin_hiz, halted & m_mode);
    chk("R3 pin_hold", pin_hold, halted & ~m_mode);
    chk("R4 osc_run", {main_osc_run, sub_osc_run}, {main_osc_en, sub_osc_en});
    chk("R5 pll_run", pll_run, exp_pll());
    chk("R6 rtc_clk_en", rtc_clk_en, exp_rtc());
    chk("R9 init_rst", init_rst, m_st == 3);
    chk("R9 op_rst", op_rst, m_op);
  endtask

  task automatic model_step();
    bit wk;
    bit nop;
    wk  = ext_wake | (rtc_irq & exp_rtc());
    nop = (m_st == 3) && !init_req && (m_cnt == 0);
    if (init_req) begin m_st = 3; m_cnt = stab_cycles; end
    else case (m_st)
      0: if (stop_wr && stop_wdata) begin m_mode = hiz_sel; m_st = wk ? 2 : 1; m_cnt = stab_cycles; end
      1: if (wk) begin m_st = 2; m_cnt = stab_cycles; end
      default: if (m_cnt == 0) m_st = 0; else m_cnt--;
    endcase
    m_op = nop;
  endtask

  task automatic drive(input bit sw, input bit wd, input bit hz, input int ld,
                       input bit ew, input bit ri, input bit ir);
    stop_wr = sw; stop_wdata = wd; hiz_sel = hz; stab_cycles = CW'(ld);
    ext_wake = ew; rtc_irq = ri; init_req = ir;
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int ld);
    drive(0, 0, 0, ld, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset state", pwr_state, 0);
    chk("R1 reset clk", core_clk_en, 1);
    chk("R1 reset outs", {stop_bit, pin_hiz, pin_hold, init_rst, op_rst}, 0);
    compare();

    main_reg_on = 0; rtc_en = 0; rtc_src_sub = 1;
    idle(3);
    drive(1, 0, 1, 3, 0, 0, 0);
    chk("R2 write zero ignored", pwr_state, 0);
    drive(1, 1, 1, 3, 0, 0, 0);
    chk("R2 entered stop", pwr_state, 1);
    chk("R5 pll off without regulator", pll_run, 0);
    drive(0, 0, 0, 3, 0, 0, 0);
    chk("R3 hiz kept after hiz_sel change", pin_hiz, 1);
    drive(0, 0, 0, 3, 0, 1, 0);
    chk("R6 rtc irq ignored when disabled", pwr_state, 1);
    rtc_en = 1;
    drive(0, 0, 0, 3, 0, 1, 0);
    chk("R7 rtc wake enters wait", pwr_state, 2);
    n = 1;
    while (pwr_state == 2 && n < 50) begin idle(0); if (pwr_state == 2) n++; end
    chk("R7 wait length", n, 4);
    chk("R7 stop bit cleared", stop_bit, 0);

    drive(1, 1, 0, 2, 1, 0, 0);
    chk("R8 same cycle wake", pwr_state, 2);
    repeat (4) idle(2);

    drive(1, 1, 0, 2, 0, 0, 0);
    chk("R3 hold mode", pin_hold, 1);
    drive(0, 0, 0, 2, 1, 0, 1);
    chk("R10 init beats wake", pwr_state, 3);
    drive(0, 0, 0, 2, 0, 0, 1);
    chk("R9 held in init", init_rst, 1);
    n = 0;
    while (pwr_state == 3 && n < 50) begin idle(9); n++; end
    chk("R9 release length", n, 3);
    chk("R9 op_rst pulse", op_rst, 1);
    idle(0);
    chk("R9 op_rst single cycle", op_rst, 0);

    for (int i = 0; i < 4000; i++) begin
      if (i % 50 == 0) begin
        main_osc_en = 1'($urandom % 4 != 0); sub_osc_en = 1'($urandom % 4 != 0);
        pll_en = 1'($urandom); main_reg_on = 1'($urandom);
        rtc_en = 1'($urandom); rtc_src_sub = 1'($urandom);
      end
      drive(1'($urandom % 4 == 0), 1'($urandom), 1'($urandom), int'($urandom % 6),
            1'($urandom % 8 == 0), 1'($urandom % 6 == 0), 1'($urandom % 40 == 0));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule